// File: doc/BRIEF.md
# Parallel Bus Programmed-I/O Data Port

This block gives a host processor direct, byte-by-byte control over a 16-bit active-low parallel data bus. It is meant for programmed transfers and for bus diagnostics. The host loads a 16-bit output latch and then sets a drive-enable bit. From that point the latch contents appear on the bus pins, inverted to the active-low convention, together with one generated parity pin per byte lane. When the drive-enable bit is clear, the pins are released, which is signalled by a low output enable.

The host can also read a live view of the bus pins. This view is not registered: it is the inverse of the pin levels at the instant of the read. A read of the view starts a parity check. In narrow mode only the low lane is checked. Wide mode is selected only when two separate configuration bits are both set. In wide mode both lanes are checked whatever the bus phase, and the high lane counts as failed outside a data phase. A failed check sets a sticky error flag. The flag drives the interrupt output until the host writes 1 to clear it.

Top module: `pio_data_port`

## Requirements
- R1: Register word 0 is the output latch. A write with `reg_be[0]` updates bits 7:0 and a write with `reg_be[1]` updates bits 15:8. Reading word 0 returns the latch.
- R2: `bus_oe` is 1 exactly while control bit 0 (drive enable, register word 2) is 1. While `bus_oe` is 1, `bus_dat_o` equals the bitwise inverse of the latch.
- R3: Reading register word 1 returns the bitwise inverse of `bus_dat_i` in the same cycle, combinationally. It tracks pin changes with no capture.
- R4: While driving, each `bus_par_o[k]` is set so that the nine pin levels of lane k (8 data bits plus its parity pin) hold an odd number of ones.
- R5: Wide mode needs both control bit 1 and control bit 2 set. Otherwise a read of word 1 (`reg_rd` high with `reg_addr` = 1) checks only lane 0, so bad parity on lane 1 does not set the error.
- R6: In wide mode a read of word 1 checks both lanes. Bad odd parity on either lane sets the error.
- R7: In wide mode a read of word 1 while `bus_phase[2:1]` is not 00 (a non-data phase) sets the error even when all parity pins are correct.
- R8: The error is bit 0 of register word 3 and it drives `irq`. It stays set until a write to word 3 with `reg_be[0]` and data bit 0 equal to 1. Writing 0 leaves it set.
- R9: A synchronous reset clears the control register and the error, so that `bus_oe`, `irq` and words 2 and 3 all read 0.
- R10: With no read of word 1, bad parity on the pins never sets the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register word select: 0 latch, 1 bus view, 2 control, 3 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (starts the parity check on word 1) |
| reg_be | input | 2 | Byte enables for writes |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data |
| bus_phase | input | 3 | Current bus phase; bits 2:1 = 00 means a data phase |
| bus_dat_i | input | 16 | Sampled data pin levels (active low) |
| bus_par_i | input | 2 | Sampled lane parity pin levels |
| bus_dat_o | output | 16 | Data pin drive levels |
| bus_par_o | output | 2 | Parity pin drive levels |
| bus_oe | output | 1 | Pin drive enable; 0 means the pins are released |
| irq | output | 1 | Parity error interrupt, active high |

## Verification
The bus view in `reg_rdata` is due in the same cycle as the address and pin values. The bench therefore samples it 1 ns after it drives the inputs, before the next rising edge. Latch, control and status writes take effect at the first rising edge after the strobe, so `bus_oe`, `bus_dat_o` and read-back values are checked after the following falling edge. A parity error from a view read reaches `irq` at that same rising edge, so `irq` is checked one falling edge after the read strobe. Before the next stimulus is applied, the error is cleared and `irq` is checked again.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int LANE_W = 8;
    localparam int LANES  = 2;
    localparam int DATA_W = LANE_W * LANES;
    localparam int PHASE_W = 3;

    typedef enum logic [1:0] {
        REG_LATCH = 2'd0,
        REG_VIEW  = 2'd1,
        REG_CTL   = 2'd2,
        REG_STAT  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wide_b;
        logic wide_a;
        logic drive;
    } ctl_t;

    // odd parity over data pins and parity pin
    function automatic logic lane_par_ok(input logic [LANE_W-1:0] pins, input logic par);
        return ^{pins, par};
    endfunction

    // parity pin level that makes the driven (inverted) lane odd
    function automatic logic lane_par_gen(input logic [LANE_W-1:0] data);
        return ~(^(~data));
    endfunction

    function automatic logic in_data_phase(input logic [PHASE_W-1:0] ph);
        return (ph[2:1] == 2'b00);
    endfunction
endpackage

// File: rtl/pio_out_latch.sv
module pio_out_latch
    import pio_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int NL = LANES,
    localparam int DW = LW * NL
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [NL-1:0] be,
    input  logic [DW-1:0] wdata,
    input  logic          drive,
    output logic [DW-1:0] latch_q,
    output logic [DW-1:0] pin_dat,
    output logic [NL-1:0] pin_par,
    output logic          pin_oe
);
    assign pin_oe = drive;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (wr_en && be[i])
                latch_q[i*LW +: LW] <= wdata[i*LW +: LW];
        end

        assign pin_dat[i*LW +: LW] = drive ? ~latch_q[i*LW +: LW] : '0;
        assign pin_par[i]          = drive ? lane_par_gen(latch_q[i*LW +: LW]) : 1'b0;

        // R1
        lane_wr_chk: assert property (@(posedge clk) disable iff (rst)
            (wr_en && be[i]) |=> latch_q[i*LW +: LW] == $past(wdata[i*LW +: LW]));

        // R4
        par_gen_chk: assert property (@(posedge clk) disable iff (rst)
            pin_oe |-> (^{pin_dat[i*LW +: LW], pin_par[i]}) == 1'b1);
    end
endmodule

// File: rtl/pio_lane_check.sv
module pio_lane_check
    import pio_pkg::*;
#(
    parameter int LW = LANE_W
) (
    input  logic          en,
    input  logic          force_bad,
    input  logic [LW-1:0] pins,
    input  logic          par,
    output logic          err
);
    logic par_good;

    always_comb begin
        par_good = ^{pins, par};
        err      = en && (force_bad || !par_good);
    end
endmodule

// File: rtl/pio_perr_flag.sv
module pio_perr_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (set)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    // R8
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr && !set) |=> !flag);
endmodule

// File: rtl/pio_data_port.sv
module pio_data_port
    import pio_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [LANES-1:0]   reg_be,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [PHASE_W-1:0] bus_phase,
    input  logic [DATA_W-1:0]  bus_dat_i,
    input  logic [LANES-1:0]   bus_par_i,
    output logic [DATA_W-1:0]  bus_dat_o,
    output logic [LANES-1:0]   bus_par_o,
    output logic               bus_oe,
    output logic               irq
);
    reg_sel_e            sel;
    ctl_t                ctl_q;
    logic [DATA_W-1:0]   latch_q;
    logic                latch_wr;
    logic                view_rd;
    logic                wide;
    logic                data_ph;
    logic [LANES-1:0]    lane_err;
    logic                perr_set;
    logic                perr_clr;
    logic                perr_q;

    assign sel      = reg_sel_e'(reg_addr);
    assign latch_wr = reg_wr && (sel == REG_LATCH);
    assign view_rd  = reg_rd && (sel == REG_VIEW);
    assign wide     = ctl_q.wide_a && ctl_q.wide_b;
    assign data_ph  = in_data_phase(bus_phase);

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= '0;
        else if (reg_wr && (sel == REG_CTL) && reg_be[0])
            ctl_q <= ctl_t'(reg_wdata[$bits(ctl_t)-1:0]);
    end

    pio_out_latch #(.LW(LANE_W), .NL(LANES)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (latch_wr),
        .be      (reg_be),
        .wdata   (reg_wdata),
        .drive   (ctl_q.drive),
        .latch_q (latch_q),
        .pin_dat (bus_dat_o),
        .pin_par (bus_par_o),
        .pin_oe  (bus_oe)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_chk
        if (k == 0) begin : g_low
            pio_lane_check #(.LW(LANE_W)) u_chk (
                .en        (view_rd),
                .force_bad (1'b0),
                .pins      (bus_dat_i[k*LANE_W +: LANE_W]),
                .par       (bus_par_i[k]),
                .err       (lane_err[k])
            );
        end else begin : g_up
            pio_lane_check #(.LW(LANE_W)) u_chk (
                .en        (view_rd && wide),
                .force_bad (!data_ph),
                .pins      (bus_dat_i[k*LANE_W +: LANE_W]),
                .par       (bus_par_i[k]),
                .err       (lane_err[k])
            );
        end
    end

    assign perr_set = |lane_err;
    assign perr_clr = reg_wr && (sel == REG_STAT) && reg_be[0] && reg_wdata[0];

    pio_perr_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (perr_set),
        .clr  (perr_clr),
        .flag (perr_q)
    );

    assign irq = perr_q;

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            REG_LATCH: reg_rdata = latch_q;
            REG_VIEW:  reg_rdata = ~bus_dat_i;
            REG_CTL:   reg_rdata[$bits(ctl_t)-1:0] = ctl_q;
            REG_STAT:  reg_rdata[0] = perr_q;
        endcase
    end

    // R2
    oe_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_oe) |-> $past(reg_wr && reg_addr == 2'd2 && reg_be[0] && reg_wdata[0]));

    // R9
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!irq && !bus_oe));

    // R10
    no_read_no_err_chk: assert property (@(posedge clk) disable iff (rst)
        (!(reg_rd && reg_addr == 2'd1) && !irq) |=> !irq);

    // R7
    wide_ctl_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == 2'd1 && wide && bus_phase[2:1] != 2'b00) |=> irq);
endmodule

// File: tb/sim_pio_data_port.sv
module sim_pio_data_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [2:0]  bus_phase = '0;
    logic [15:0] bus_dat_i;
    logic [1:0]  bus_par_i;
    logic [15:0] bus_dat_o;
    logic [1:0]  bus_par_o;
    logic        bus_oe;
    logic        irq;

    logic [15:0] ext_dat = 16'hFFFF;
    logic [1:0]  ext_par = 2'b11;
    logic        loop = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    assign bus_dat_i = (loop && bus_oe) ? bus_dat_o : ext_dat;
    assign bus_par_i = (loop && bus_oe) ? bus_par_o : ext_par;

    pio_data_port u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .bus_phase(bus_phase), .bus_dat_i(bus_dat_i), .bus_par_i(bus_par_i),
        .bus_dat_o(bus_dat_o), .bus_par_o(bus_par_o), .bus_oe(bus_oe), .irq(irq)
    );

    function automatic bit odd9(input logic [7:0] d, input logic p);
        int n = 0;
        for (int i = 0; i < 8; i++) if (d[i]) n++;
        if (p) n++;
        return (n % 2) == 1;
    endfunction

    function automatic logic gen_par(input logic [7:0] latch);
        return odd9(~latch, 1'b0) ? 1'b0 : 1'b1;
    endfunction

    function automatic bit exp_err(input logic [15:0] d, input logic [1:0] p,
                                   input bit wide, input logic [2:0] ph);
        bit e = !odd9(d[7:0], p[0]);
        if (wide) begin
            if (!odd9(d[15:8], p[1])) e = 1;
            if (ph[2:1] != 2'b00) e = 1;
        end
        return e;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_be = be; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic view_read(output logic [15:0] v);
        @(negedge clk);
        reg_addr = 2'd1; reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic clear_err();
        wr(2'd3, 16'h0001, 2'b01);
    endtask

    task automatic set_ctl(input bit drive, input bit wa, input bit wb);
        wr(2'd2, {13'd0, wb, wa, drive}, 2'b01);
    endtask

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual %h expected %h", 0, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [15:0] latch_m;
        logic [15:0] unused_seed;
        unused_seed = 16'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd_reg(2'd2, v);
        chk(v == 16'h0 && !bus_oe && !irq, "R9 ctl/oe/irq", {v, 7'd0, bus_oe, 7'd0, irq}, 0);
        rd_reg(2'd3, v);
        chk(v == 16'h0, "R9 status", v, 0);

        // R1 latch writes with byte enables
        wr(2'd0, 16'hA5C3, 2'b11);
        rd_reg(2'd0, v); chk(v == 16'hA5C3, "R1 full", v, 16'hA5C3);
        wr(2'd0, 16'hFF11, 2'b01);
        rd_reg(2'd0, v); chk(v == 16'hA511, "R1 low lane", v, 16'hA511);
        wr(2'd0, 16'h7722, 2'b10);
        rd_reg(2'd0, v); chk(v == 16'h7711, "R1 high lane", v, 16'h7711);
        latch_m = 16'h7711;

        // R2 drive enable
        chk(!bus_oe, "R2 released", bus_oe, 0);
        set_ctl(1, 0, 0);
        #1;
        chk(bus_oe == 1'b1, "R2 oe on", bus_oe, 1);
        chk(bus_dat_o == ~latch_m, "R2 pins", bus_dat_o, ~latch_m);
        // R4 parity generation
        chk(bus_par_o == {gen_par(latch_m[15:8]), gen_par(latch_m[7:0])}, "R4 par",
            bus_par_o, {gen_par(latch_m[15:8]), gen_par(latch_m[7:0])});
        wr(2'd0, 16'h0180, 2'b11);
        latch_m = 16'h0180;
        #1;
        chk(bus_par_o == {gen_par(8'h01), gen_par(8'h80)}, "R4 par 2", bus_par_o,
            {gen_par(8'h01), gen_par(8'h80)});
        chk(bus_dat_o == ~latch_m, "R2 pins 2", bus_dat_o, ~latch_m);

        // R4 loopback in wide data phase: driven parity passes the check
        set_ctl(1, 1, 1);
        loop = 1'b1; bus_phase = 3'b001;
        view_read(v);
        chk(v == latch_m, "R3 loopback view", v, latch_m);
        chk(!irq, "R4 loopback no error", irq, 0);
        loop = 1'b0;
        set_ctl(0, 0, 0);
        #1 chk(!bus_oe, "R2 oe off", bus_oe, 0);

        // R3 unlatched view
        @(negedge clk);
        reg_addr = 2'd1; ext_dat = 16'h1234;
        #1 chk(reg_rdata == 16'hEDCB, "R3 view", reg_rdata, 16'hEDCB);
        ext_dat = 16'h00F0;
        #1 chk(reg_rdata == 16'hFF0F, "R3 tracks", reg_rdata, 16'hFF0F);

        // R10 bad parity, no read
        set_ctl(0, 1, 1);
        ext_dat = 16'h0000; ext_par = 2'b00; bus_phase = 3'b110;
        repeat (5) @(negedge clk);
        chk(!irq, "R10 no read", irq, 0);

        // R5 narrow, bad high lane ignored
        set_ctl(0, 1, 0);
        ext_dat = 16'h0000; ext_par = 2'b01; bus_phase = 3'b000;
        view_read(v);
        chk(!irq, "R5 narrow high ignored", irq, 1'b0);
        set_ctl(0, 0, 1);
        bus_phase = 3'b100;
        view_read(v);
        chk(!irq, "R5 one bit nondata", irq, 1'b0);

        // R6 wide, bad high lane
        set_ctl(0, 1, 1);
        bus_phase = 3'b000;
        view_read(v);
        chk(irq, "R6 wide high bad", irq, 1);
        // R8 sticky, write 0 keeps it
        repeat (4) @(negedge clk);
        chk(irq, "R8 sticky", irq, 1);
        wr(2'd3, 16'h0000, 2'b01);
        chk(irq, "R8 write zero", irq, 1);
        rd_reg(2'd3, v);
        chk(v == 16'h0001, "R8 status read", v, 1);
        clear_err();
        chk(!irq, "R8 cleared", irq, 0);

        // R7 wide non-data phase with good parity
        ext_par = 2'b11; bus_phase = 3'b010;
        view_read(v);
        chk(irq, "R7 nondata", irq, 1);
        clear_err();

        // random mix
        for (int n = 0; n < 200; n++) begin
            logic [2:0] c;
            logic [15:0] d;
            logic [1:0] p;
            logic [2:0] ph;
            bit e;
            c  = 3'($urandom);
            d  = 16'($urandom);
            p  = 2'($urandom);
            ph = 3'($urandom);
            set_ctl(0, c[0], c[1]);
            ext_dat = d; ext_par = p; bus_phase = ph;
            e = exp_err(d, p, c[0] && c[1], ph);
            view_read(v);
            chk(v == ~d, "R3 random view", v, ~d);
            chk(irq == e, (c[0] && c[1]) ? "R6/R7 random wide" : "R5 random narrow", irq, e);
            clear_err();
            chk(!irq, "R8 random clear", irq, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule